// File: doc/BRIEF.md
# Bus Parity Generation and Checking Unit

This block produces and checks even parity for a 64-bit multiplexed address/data bus of the PCI family. The bus is split into two lanes. The low lane covers AD[31:0] together with C/BE#[3:0]. The high lane covers AD[63:32] together with C/BE#[7:4]. Each lane's parity bit is registered, so it appears on the bus exactly one clock after the address or data value it covers. The unit works in both address and data phases.

The surrounding transaction logic tells the unit four things each clock: the phase type, the bridge's role (initiator or target), the transfer direction, and whether the bridge is driving AD. From these the unit decides whether to drive parity or to check the parity driven by the other agent.

When a checked data phase completes, the unit compares the parity that arrives on the next clock with its own computed value. On a mismatch it asserts an active-low parity-error strobe for one clock. It then drives that line high for one more clock before releasing it. The high lane takes part only when the 64-bit request/acknowledge handshake completed.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_o` is the XOR of all 36 bits AD[31:0] and C/BE#[3:0], so that those 36 bits plus `par_o` hold an even number of ones. All four byte-enable lanes are included even when every C/BE# bit is 1 (no byte enabled).
- R2: `par_o` and `par64_o` show, after a rising edge, the parity of the bus values sampled at the previous rising edge. This one-clock delay holds in address phases and in data phases alike.
- R3: `par64_o` is the XOR of AD[63:32] and C/BE#[7:4].
- R4: `par_oe_o` is 1 in the clock after a clock in which `ad_oe_i`=1 and the role calls for driving. The role calls for driving in an address phase (`addr_phase_i`=1) with `initiator_i`=1, in a data phase as initiator of a write (`initiator_i`=1, `write_i`=1), and in a data phase as target of a read (`initiator_i`=0, `write_i`=0). Otherwise `par_oe_o` is 0.
- R5: `par64_oe_o` equals `par_oe_o` qualified by the wide condition of the previous clock. In an address phase the wide condition is `req64_n_i`=0. In a data phase it is `req64_n_i`=0 and `ack64_n_i`=0.
- R6: A data phase is checked only as initiator of a read or as target of a write, and only when `irdy_n_i`=0 and `trdy_n_i`=0 in that clock. The `par_i` value of the following clock is compared with the low-lane parity of the checked phase.
- R7: On a mismatch, `perr_n_o`=0 and `perr_oe_o`=1 during the clock that follows the edge at which the bad parity was sampled. That is two edges after the failing data phase, and the strobe lasts one clock.
- R8: In the clock after an asserted strobe, `perr_oe_o` stays 1 with `perr_n_o`=1. It then falls to 0 unless a new error follows.
- R9: `par64_i` is compared only when the checked phase met the data-phase wide condition. Otherwise a wrong `par64_i` leaves `perr_n_o` at 1.
- R10: Address phases, data phases without both ready signals low, and data phases in a driving role are never checked. Wrong `par_i` after them leaves `perr_n_o` at 1.
- R11: During reset all outputs are 0 except `perr_n_o`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 64 | Sampled address/data bus |
| cbe_n_i | input | 8 | Sampled command/byte-enable bus, active low |
| addr_phase_i | input | 1 | 1 = address phase this clock |
| initiator_i | input | 1 | 1 = bridge is initiator, 0 = target |
| write_i | input | 1 | 1 = write transfer, 0 = read |
| ad_oe_i | input | 1 | 1 = bridge drives AD this clock |
| req64_n_i | input | 1 | 64-bit request, active low |
| ack64_n_i | input | 1 | 64-bit acknowledge, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| par_i | input | 1 | Sampled low-lane parity |
| par64_i | input | 1 | Sampled high-lane parity |
| par_o | output | 1 | Generated low-lane parity |
| par_oe_o | output | 1 | Drive enable for `par_o` |
| par64_o | output | 1 | Generated high-lane parity |
| par64_oe_o | output | 1 | Drive enable for `par64_o` |
| perr_n_o | output | 1 | Parity error strobe, active low |
| perr_oe_o | output | 1 | Drive enable for `perr_n_o` |

## Verification
Generation and checking overlap in time. The error strobe for one phase lands in the same clock in which the unit drives parity for the next phase. The bench provokes this with back-to-back phases: a checked initiator read is followed at once by a target read that the bridge drives, and corrupted parity is supplied in that second clock. A later error arrives while the release clock of the previous strobe is still running. Each clock, a scoreboard compares all six outputs as one item against values the bench computes from the requirements. A late or missing strobe, a wrong enable, or a wrong parity bit in the overlap cycle is therefore caught in the very cycle where it occurs.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;
    parameter int unsigned LANES = 2;

    typedef struct packed {
        logic [LANES-1:0] par;       // generated parity per lane
        logic [LANES-1:0] oe;        // drive enable per lane
        logic [LANES-1:0] chk;       // lane compare armed for next clock
        logic [LANES-1:0] exp;       // expected parity per lane
        logic             perr;      // error strobe active
        logic             perr_hold; // drive-high release clock
    } par_state_t;
endpackage

// File: rtl/pci_par_lane.sv
module pci_par_lane #(
    parameter int unsigned DW = 32,
    parameter int unsigned BW = 4
) (
    input  logic [DW-1:0] ad,
    input  logic [BW-1:0] cbe_n,
    output logic          even_par
);
    always_comb begin
        even_par = ^{ad, cbe_n};
    end
endmodule

// File: rtl/pci_par_role.sv
module pci_par_role (
    input  logic addr_phase,
    input  logic initiator,
    input  logic write,
    input  logic req64_n,
    input  logic ack64_n,
    input  logic irdy_n,
    input  logic trdy_n,
    output logic drive_own,
    output logic check_own,
    output logic wide
);
    logic done;

    always_comb begin
        done      = !irdy_n && !trdy_n;
        drive_own = addr_phase ? initiator : (initiator == write);
        check_own = !addr_phase && (initiator != write) && done;
        wide      = addr_phase ? !req64_n : (!req64_n && !ack64_n);
    end
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter  int unsigned LANE_AD_W = 32,
    parameter  int unsigned LANE_BE_W = 4,
    localparam int unsigned AD_W      = LANE_AD_W * LANES,
    localparam int unsigned BE_W      = LANE_BE_W * LANES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_n_i,
    input  logic            addr_phase_i,
    input  logic            initiator_i,
    input  logic            write_i,
    input  logic            ad_oe_i,
    input  logic            req64_n_i,
    input  logic            ack64_n_i,
    input  logic            irdy_n_i,
    input  logic            trdy_n_i,
    input  logic            par_i,
    input  logic            par64_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            par64_o,
    output logic            par64_oe_o,
    output logic            perr_n_o,
    output logic            perr_oe_o
);
    par_state_t       st_d, st_q;
    logic [LANES-1:0] lane_par;
    logic [LANES-1:0] bus_par;
    logic             drive_own, check_own, wide;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            pci_par_lane #(
                .DW (LANE_AD_W),
                .BW (LANE_BE_W)
            ) u_lane (
                .ad       (ad_i[g*LANE_AD_W +: LANE_AD_W]),
                .cbe_n    (cbe_n_i[g*LANE_BE_W +: LANE_BE_W]),
                .even_par (lane_par[g])
            );
        end
    endgenerate

    pci_par_role u_role (
        .addr_phase (addr_phase_i),
        .initiator  (initiator_i),
        .write      (write_i),
        .req64_n    (req64_n_i),
        .ack64_n    (ack64_n_i),
        .irdy_n     (irdy_n_i),
        .trdy_n     (trdy_n_i),
        .drive_own  (drive_own),
        .check_own  (check_own),
        .wide       (wide)
    );

    always_comb begin
        bus_par = {par64_i, par_i};
    end

    always_comb begin
        logic mism;
        st_d     = st_q;
        st_d.par = lane_par;
        st_d.exp = lane_par;
        mism     = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            if (l == 0) begin
                st_d.oe[l]  = ad_oe_i && drive_own;
                st_d.chk[l] = check_own;
            end else begin
                st_d.oe[l]  = ad_oe_i && drive_own && wide;
                st_d.chk[l] = check_own && wide;
            end
            if (st_q.chk[l] && (bus_par[l] != st_q.exp[l])) begin
                mism = 1'b1;
            end
        end
        st_d.perr      = mism;
        st_d.perr_hold = st_q.perr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        par_o      = st_q.par[0];
        par64_o    = st_q.par[LANES-1];
        par_oe_o   = st_q.oe[0];
        par64_oe_o = st_q.oe[LANES-1];
        perr_n_o   = !st_q.perr;
        perr_oe_o  = st_q.perr || st_q.perr_hold;
    end
endmodule

// File: rtl/pci_parity_chk.sv
module pci_parity_chk #(
    parameter int unsigned LANE_AD_W = 32,
    parameter int unsigned LANE_BE_W = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [LANE_AD_W-1:0] ad_lo,
    input logic [LANE_BE_W-1:0] cbe_lo,
    input logic                 ad_oe_i,
    input logic                 irdy_n_i,
    input logic                 trdy_n_i,
    input logic                 par_o,
    input logic                 par_oe_o,
    input logic                 par64_oe_o,
    input logic                 perr_n_o,
    input logic                 perr_oe_o
);
    // R2
    par_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (par_o == ^$past({ad_lo, cbe_lo})));

    // R4
    par_oe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (!par_oe_o || $past(ad_oe_i)));

    // R5
    wide_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par64_oe_o |-> par_oe_o);

    // R7
    perr_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |-> perr_oe_o);

    // R8
    perr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_n_o |=> perr_oe_o);

    // R10
    no_check_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irdy_n_i || trdy_n_i) |=> ##1 perr_n_o);
endmodule

bind pci_parity_unit pci_parity_chk #(
    .LANE_AD_W (LANE_AD_W),
    .LANE_BE_W (LANE_BE_W)
) u_parity_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad_lo      (ad_i[LANE_AD_W-1:0]),
    .cbe_lo     (cbe_n_i[LANE_BE_W-1:0]),
    .ad_oe_i    (ad_oe_i),
    .irdy_n_i   (irdy_n_i),
    .trdy_n_i   (trdy_n_i),
    .par_o      (par_o),
    .par_oe_o   (par_oe_o),
    .par64_oe_o (par64_oe_o),
    .perr_n_o   (perr_n_o),
    .perr_oe_o  (perr_oe_o)
);

// File: tb/pci_parity_unit_tb_top.sv
module pci_parity_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ad_i = '0;
    logic [7:0]  cbe_n_i = '1;
    logic        addr_phase_i = 1'b0, initiator_i = 1'b0, write_i = 1'b0, ad_oe_i = 1'b0;
    logic        req64_n_i = 1'b1, ack64_n_i = 1'b1, irdy_n_i = 1'b1, trdy_n_i = 1'b1;
    logic        par_i = 1'b0, par64_i = 1'b0;
    logic        par_o, par_oe_o, par64_o, par64_oe_o, perr_n_o, perr_oe_o;

    int checks = 0;
    int fails  = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        logic [5:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    // bench-side model state of the previous clock
    logic pend_chk = 1'b0, pend_wide = 1'b0, pend_lo = 1'b0, pend_hi = 1'b0, prev_mis = 1'b0;

    always #5 clk = ~clk;

    pci_parity_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_n_i(cbe_n_i),
        .addr_phase_i(addr_phase_i), .initiator_i(initiator_i), .write_i(write_i),
        .ad_oe_i(ad_oe_i), .req64_n_i(req64_n_i), .ack64_n_i(ack64_n_i),
        .irdy_n_i(irdy_n_i), .trdy_n_i(trdy_n_i), .par_i(par_i), .par64_i(par64_i),
        .par_o(par_o), .par_oe_o(par_oe_o), .par64_o(par64_o), .par64_oe_o(par64_oe_o),
        .perr_n_o(perr_n_o), .perr_oe_o(perr_oe_o)
    );

    always @(posedge clk) begin
        if (rst_n) cyc_cnt = cyc_cnt + 1;
    end

    // monitor: pops items due in the current clock, compares all outputs
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].due <= cyc_cnt) begin
                item_t it;
                logic [5:0] act;
                it  = sbq.pop_front();
                act = {par_o, par_oe_o, par64_o, par64_oe_o, perr_n_o, perr_oe_o};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: {par,oe,par64,oe64,perr_n,perr_oe} actual=%b expected=%b",
                             it.tag, act, it.exp);
                end
            end
        end
    end

    // driver: applies one clock of stimulus and pushes the expected outputs
    task automatic step(input logic [63:0] ad, input logic [7:0] be,
                        input logic ap, input logic ini, input logic wr, input logic oe,
                        input logic r64, input logic a64, input logic ir, input logic tr,
                        input logic fl, input logic fh, input string tag);
        item_t it;
        logic lo, hi, drv, wide, chk, mis;
        @(negedge clk);
        ad_i = ad; cbe_n_i = be; addr_phase_i = ap; initiator_i = ini; write_i = wr;
        ad_oe_i = oe; req64_n_i = r64; ack64_n_i = a64; irdy_n_i = ir; trdy_n_i = tr;
        par_i = pend_lo ^ fl;
        par64_i = pend_hi ^ fh;
        lo   = ^{ad[31:0], be[3:0]};
        hi   = ^{ad[63:32], be[7:4]};
        drv  = oe && (ap ? ini : (ini == wr));
        wide = ap ? !r64 : (!r64 && !a64);
        chk  = !ap && (ini != wr) && !ir && !tr;
        mis  = pend_chk && (fl || (pend_wide && fh));
        it.due = cyc_cnt + 1;
        it.exp = {lo, drv, hi, drv && wide, !mis, mis || prev_mis};
        it.tag = tag;
        sbq.push_back(it);
        prev_mis  = mis;
        pend_chk  = chk;
        pend_wide = chk && wide;
        pend_lo   = lo;
        pend_hi   = hi;
    endtask

    task automatic idle(input logic fl, input logic fh, input string tag);
        step(64'h0, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, fl, fh, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({par_o, par_oe_o, par64_o, par64_oe_o, perr_n_o, perr_oe_o} !== 6'b000010) begin
            fails++;
            $display("FAIL R11 reset: actual=%b expected=%b",
                     {par_o, par_oe_o, par64_o, par64_oe_o, perr_n_o, perr_oe_o}, 6'b000010);
        end
        rst_n = 1'b1;

        // R1 byte enables all off, address phase as initiator, 32-bit
        step(64'h0000_0000_0000_0007, 8'hFF, 1, 1, 1, 1, 1, 1, 1, 1, 0, 0, "R1 R4 addr no-BE");
        // R3 R5 address phase with 64-bit request
        step(64'hF00D_0001_1234_5678, 8'h36, 1, 1, 0, 1, 0, 1, 1, 1, 0, 0, "R3 R5 addr wide");
        // R2 R5 initiator write data, handshake complete
        step(64'hDEAD_BEEF_0BAD_F00D, 8'h00, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R2 R5 ini write wide");
        // R5 acknowledge missing
        step(64'h1357_9BDF_2468_ACE0, 8'h5A, 0, 1, 1, 1, 0, 1, 0, 0, 0, 0, "R5 ini write narrow");
        // R4 target read drives
        step(64'h8000_0000_0000_0001, 8'h81, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R4 tgt read drive");
        // R4 target write must not drive; R6 checked phase
        step(64'h0F0F_0F0F_F0F0_F0F0, 8'h0F, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0, "R4 tgt write no drive");
        idle(0, 0, "R6 good parity no error");
        // R9 wide initiator read, bad upper parity
        step(64'hCAFE_BABE_1111_2222, 8'h3C, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R6 ini read wide");
        idle(0, 1, "R9 upper mismatch sampled");
        idle(0, 0, "R7 strobe low");
        idle(0, 0, "R8 release drive high");
        idle(0, 0, "R8 released");
        // R9 narrow check ignores upper parity
        step(64'h7777_8888_9999_AAAA, 8'hC3, 0, 0, 1, 0, 0, 1, 0, 0, 0, 0, "R9 tgt write narrow");
        idle(0, 1, "R9 upper ignored");
        idle(0, 0, "R9 no strobe");
        // R10 phase not completed
        step(64'h0000_FFFF_0000_FFFF, 8'hA5, 0, 0, 1, 0, 1, 1, 1, 0, 0, 0, "R10 not ready");
        idle(1, 0, "R10 bad par after incomplete");
        idle(0, 0, "R10 no strobe a");
        // R10 driving role not checked
        step(64'h0123_4567_89AB_CDEF, 8'h00, 0, 1, 1, 1, 1, 1, 0, 0, 0, 0, "R10 ini write");
        idle(1, 0, "R10 bad par after own write");
        idle(0, 0, "R10 no strobe b");
        // R10 address phase not checked
        step(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 1, 0, 1, 0, 1, 1, 0, 0, 0, 0, "R10 addr phase");
        idle(1, 1, "R10 bad par after addr");
        idle(0, 0, "R10 no strobe c");
        // overlap: strobe while driving parity for the next phase
        step(64'h0000_0000_A5A5_5A5A, 8'hF0, 0, 1, 0, 0, 1, 1, 0, 0, 0, 0, "R6 ini read narrow");
        step(64'h5555_AAAA_3333_CCCC, 8'h99, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, "R7 R4 drive with bad sample");
        step(64'h0000_0001_0000_0001, 8'h11, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0, "R7 R2 strobe overlap");
        step(64'h0, 8'hFF, 0, 0, 0, 1, 1, 1, 1, 1, 1, 0, "R8 R7 error during release");
        idle(0, 0, "R7 second strobe");
        idle(0, 0, "R8 second release");
        // R1 R2 R3 sweep of patterns
        for (int i = 0; i < 8; i++) begin
            logic [63:0] pat;
            pat = {32'h9E37_79B9 * (i + 1), ~(32'h85EB_CA6B * i)};
            step(pat, 8'(i * 37), 0, 1, 1, 1, 0, 0, 0, 0, 0, 0, "R1 R2 R3 sweep");
        end
        idle(0, 0, "R2 tail");
        repeat (3) @(negedge clk);
        checks++;
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sbq.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule